// File: doc/BRIEF.md
# Two-Stage SPI Clock Prescaler

This block derives the serial clock of an SPI master from a faster main clock. The division is done in two stages. A power-of-two stage divides the main clock by 2, 4, 8 or 16 according to a 2-bit pre-scale select. An even stage then divides that tick rate by 2·(B+1), where B is a 6-bit rate value. One serial clock half-period therefore lasts (2 << pre-scale)·(B+1) main-clock cycles. B is limited to the range 4..63, and any smaller value is raised to 4. This keeps the fastest serial clock at one twentieth of the main clock. The slowest serial clock is one 2048th of the main clock.

A shift engine sits beside the block and uses its outputs. It starts the clock by raising the enable. The pre-scale select, the rate value and the polarity are captured while the block is idle, so a shift engine can set them up freely between transfers. The block also drives two single-cycle strobes. One marks each edge that leaves the idle level and the other marks each edge that returns to it, so the shift engine can sample or launch data without looking for edges itself. When the enable drops, the clock finishes its current half-period, then settles at its idle level.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, `sclk` is 0 and both `lead_stb` and `trail_stb` are 0.
- R2: While the block is idle, `sclk` follows `cpol` with one cycle of latency (`cpol`=1 idles high, `cpol`=0 idles low), and no strobe is raised.
- R3: While running, each half-period of `sclk` lasts H = (2 << `pre_sel`) · (B+1) main-clock cycles, where B is the effective rate value.
- R4: The first edge that leaves the idle level comes H cycles after the clock edge that first samples `en` high in the idle state. `lead_stb` is seen in the cycle after that edge.
- R5: A `rate_sel` value below 4 acts exactly like 4. For example, `pre_sel`=2 with `rate_sel`=0 gives H=40.
- R6: `lead_stb` is high for exactly one cycle, in the cycle in which `sclk` first shows the non-idle level. `trail_stb` is high for exactly one cycle, in the cycle in which `sclk` first shows the idle level again.
- R7: If `en` is low when a non-idle half-period ends, `sclk` returns to idle with a trailing strobe. After that no further strobe occurs until `en` rises again.
- R8: If `en` is low when an idle-level half-period ends, the clock stops with no further edge and no strobe.
- R9: `pre_sel`, `rate_sel` and `cpol` are sampled only while idle, including the edge that starts the clock. Changes made while the clock runs do not affect its period or its level.
- R10: `lead_stb` and `trail_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request for the serial clock |
| pre_sel | input | 2 | Power-of-two pre-scale select (ratio 2 << pre_sel) |
| rate_sel | input | 6 | Even-stage rate value B, floor 4 |
| cpol | input | 1 | Idle level of sclk |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe at each edge leaving the idle level |
| trail_stb | output | 1 | One-cycle strobe at each edge returning to the idle level |

## Verification
A wrong count in either divider stage changes the spacing of the strobes. That error shows up within the first half-period after the enable rises, as a wrong distance between the enable and the first leading strobe, or between one strobe and the next. A bad run/stop state or a bad phase bit shows as `sclk` sitting at the wrong level at a strobe, or as strobes that keep arriving after the enable has dropped. The bench therefore measures those distances and levels for several pre-scale and rate settings, including rate values below the floor. It also stops the clock in each half, and changes the settings while the clock runs.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int PRE_SEL_W = 2;
    localparam int RATE_W    = 6;
    localparam int RATE_MIN  = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } edge_evt_t;

    function automatic int unsigned floor_to(input int unsigned v, input int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int unsigned pre_ratio(input int unsigned sel);
        return 32'd2 << sel;
    endfunction

endpackage

// File: rtl/presc_cfg_hold.sv
module presc_cfg_hold
    import spi_presc_pkg::*;
#(
    parameter int SEL_W  = PRE_SEL_W,
    parameter int RW     = RATE_W,
    parameter int R_MIN  = RATE_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [RW-1:0] rate_in,
    input  logic          pol_in,
    output logic [SEL_W-1:0] sel_q,
    output logic [RW-1:0] rate_q,
    output logic          pol_q
);

    logic [RW-1:0] rate_fl;

    always_comb begin
        rate_fl = RW'(floor_to(32'(rate_in), R_MIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            rate_q <= RW'(R_MIN);
            pol_q  <= 1'b0;
        end else if (!run) begin
            sel_q  <= sel_in;
            rate_q <= rate_fl;
            pol_q  <= pol_in;
        end
    end

    // R5: the held rate value never drops under the floor
    p_rate_floor_r5: assert property (@(posedge clk) disable iff (rst)
        rate_q >= RW'(R_MIN));

    // R9: settings stay frozen while the clock keeps running
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> ($stable(sel_q) && $stable(rate_q) && $stable(pol_q)));

endmodule

// File: rtl/presc_pow2_stage.sv
module presc_pow2_stage
    import spi_presc_pkg::*;
#(
    parameter int SEL_W = PRE_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int RATIO_MAX = 2 << ((1 << SEL_W) - 1);
    localparam int CW        = $clog2(RATIO_MAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_v;

    always_comb begin
        last_v = CW'(pre_ratio(32'(sel)) - 1);
        tick   = run && (cnt == last_v);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == last_v) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the pre-scale count never passes its terminal value
    p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_v);

endmodule

// File: rtl/presc_even_stage.sv
module presc_even_stage
    import spi_presc_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    output logic          half_done
);

    logic [RW-1:0] cnt;

    always_comb begin
        half_done = tick && (cnt == rate);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == rate) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: the tick count stays inside one half-period
    p_rate_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= rate);

endmodule

// File: rtl/presc_edge_gen.sv
module presc_edge_gen
    import spi_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       half_done,
    output run_state_t st,
    output logic       act,
    output edge_evt_t  evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_IDLE;
            act <= 1'b0;
            evt <= '0;
        end else begin
            evt <= '0;
            case (st)
                PH_IDLE: begin
                    act <= 1'b0;
                    if (en) begin
                        st <= PH_RUN;
                    end
                end
                default: begin
                    if (half_done) begin
                        if (act) begin
                            act       <= 1'b0;
                            evt.trail <= 1'b1;
                            if (!en) begin
                                st <= PH_IDLE;
                            end
                        end else if (en) begin
                            act      <= 1'b1;
                            evt.lead <= 1'b1;
                        end else begin
                            st <= PH_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // R10: the two strobes exclude each other
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(evt.lead && evt.trail));

    // R6: each strobe lasts one cycle and matches the phase it marks
    p_lead_single_r6: assert property (@(posedge clk) disable iff (rst)
        evt.lead |=> !evt.lead);
    p_trail_single_r6: assert property (@(posedge clk) disable iff (rst)
        evt.trail |=> !evt.trail);
    p_lead_phase_r6: assert property (@(posedge clk) disable iff (rst)
        evt.lead |-> act);
    p_trail_phase_r6: assert property (@(posedge clk) disable iff (rst)
        evt.trail |-> !act);

    // R8: a stopped clock sits in its idle phase
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE) |-> !act);

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_presc_pkg::*;
#(
    parameter int SEL_W = PRE_SEL_W,
    parameter int RW    = RATE_W,
    parameter int R_MIN = RATE_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic [RW-1:0]    rate_sel,
    input  logic             cpol,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);

    run_state_t       st;
    logic             run;
    logic [SEL_W-1:0] sel_q;
    logic [RW-1:0]    rate_q;
    logic             pol_q;
    logic             tick;
    logic             half_done;
    logic             act;
    edge_evt_t        evt;

    always_comb begin
        run = (st == PH_RUN);
    end

    presc_cfg_hold #(.SEL_W(SEL_W), .RW(RW), .R_MIN(R_MIN)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .sel_in  (pre_sel),
        .rate_in (rate_sel),
        .pol_in  (cpol),
        .sel_q   (sel_q),
        .rate_q  (rate_q),
        .pol_q   (pol_q)
    );

    presc_pow2_stage #(.SEL_W(SEL_W)) u_pow2 (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (sel_q),
        .tick (tick)
    );

    presc_even_stage #(.RW(RW)) u_even (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (tick),
        .rate      (rate_q),
        .half_done (half_done)
    );

    presc_edge_gen u_edge (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .half_done (half_done),
        .st        (st),
        .act       (act),
        .evt       (evt)
    );

    always_comb begin
        sclk      = act ^ pol_q;
        lead_stb  = evt.lead;
        trail_stb = evt.trail;
    end

    // R2: an idle clock shows the polarity sampled one cycle earlier
    p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> (sclk == $past(cpol)));

    // R2: no strobe while idle for two cycles
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> (!lead_stb && !trail_stb));

endmodule

// File: tb/sim_spi_sclk_prescaler.sv
module sim_spi_sclk_prescaler;

    localparam int CLK_P = 10;
    localparam int NVEC  = 6;
    localparam int WD_LIMIT = 150000;
    // fields: [8] cpol, [7:6] pre_sel, [5:0] rate_sel
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 6'd4},
        {1'b1, 2'd1, 6'd10},
        {1'b0, 2'd3, 6'd63},
        {1'b1, 2'd2, 6'd0},
        {1'b0, 2'd0, 6'd3},
        {1'b1, 2'd3, 6'd5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [5:0] rate_sel = 6'd4;
    logic       cpol = 1'b0;
    logic       sclk;
    logic       lead_stb;
    logic       trail_stb;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    spi_sclk_prescaler u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .pre_sel   (pre_sel),
        .rate_sel  (rate_sel),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int half_of(input int ps, input int rs);
        int b;
        b = (rs < 4) ? 4 : rs;
        return (b + 1) * (2 << ps);
    endfunction

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic count_until(input bit want_lead, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_lead ? lead_stb : trail_stb) && n < limit);
    endtask

    task automatic watch_quiet(input int span, input bit lvl, input string req);
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            if (lead_stb || trail_stb || sclk != lvl) ok = 1'b0;
        end
        chk(ok, req, int'(ok), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int h;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 reset", int'(sclk), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 after reset", int'(sclk), 0);

        // R2: idle level follows polarity
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R2 idle high", int'(sclk), 1);
        chk(!lead_stb && !trail_stb, "R2 idle quiet", int'(lead_stb), 0);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R2 idle low", int'(sclk), 0);

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            cpol     = VEC[i][8];
            pre_sel  = VEC[i][7:6];
            rate_sel = VEC[i][5:0];
            h = half_of(int'(VEC[i][7:6]), int'(VEC[i][5:0]));
            repeat (3) @(negedge clk);
            chk(sclk == cpol, "R2 idle level", int'(sclk), int'(cpol));
            en = 1'b1;
            count_until(1'b1, 4 * h + 8, n);
            chk(n == h + 1, (VEC[i][5:0] < 4) ? "R5 R4 first lead" : "R4 first lead", n, h + 1);
            chk(sclk == ~cpol, "R6 level at lead", int'(sclk), int'(~cpol));
            count_until(1'b0, 4 * h + 8, n);
            chk(n == h, (VEC[i][5:0] < 4) ? "R5 R3 lead to trail" : "R3 lead to trail", n, h);
            chk(sclk == cpol, "R6 level at trail", int'(sclk), int'(cpol));
            count_until(1'b1, 4 * h + 8, n);
            chk(n == h, "R3 trail to lead", n, h);
            en = 1'b0;
            count_until(1'b0, 4 * h + 8, n);
            chk(n == h, "R7 stop from active half", n, h);
            watch_quiet(3 * h, cpol, "R7 quiet after stop");
        end

        // R6 R10: single-cycle strobes
        cpol = 1'b0; pre_sel = 2'd0; rate_sel = 6'd4;
        repeat (2) @(negedge clk);
        en = 1'b1;
        count_until(1'b1, 100, n);
        @(negedge clk);
        chk(!lead_stb && !trail_stb, "R6 R10 lead one cycle", int'(lead_stb), 0);
        count_until(1'b0, 100, n);
        chk(n == 9, "R3 trail spacing", n, 9);
        // R8: stop during idle-level half
        en = 1'b0;
        watch_quiet(50, 1'b0, "R8 stop from idle half");

        // R9: changes while running are ignored
        cpol = 1'b0; pre_sel = 2'd0; rate_sel = 6'd4;
        repeat (2) @(negedge clk);
        en = 1'b1;
        count_until(1'b1, 100, n);
        pre_sel = 2'd3; rate_sel = 6'd20; cpol = 1'b1;
        count_until(1'b0, 2000, n);
        chk(n == 10, "R9 period frozen", n, 10);
        chk(sclk == 1'b0, "R9 polarity frozen", int'(sclk), 0);
        count_until(1'b1, 2000, n);
        chk(n == 10 && sclk == 1'b1, "R9 period frozen second half", n, 10);
        en = 1'b0;
        count_until(1'b0, 2000, n);
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R9 new polarity taken when idle", int'(sclk), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule